// File: doc/BRIEF.md
# PWM and Pulse-Count Modulation Generator

This block turns a programmed duty value into a single-bit drive signal over a repeating period. A free-running period timer counts through each period. A magnitude comparator holds the output high while the duty compare value is greater than the timer. A mode bit passes the timer through a bit-reversal network before the comparison. With that bit clear, the ON time is one contiguous run at the start of each period, which is standard PWM. With it set, the same number of ON clocks is spread across the period as evenly as the bit-reversed ordering allows, which is pulse-count modulation. The faster edge rate of the second mode suits a low-pass-filtered D/A stage.

Software writes the period, the duty value and a shadow duty value through a small register write port. A shadow-transfer strobe copies the shadow into the live duty register in one clock, so a new duty can be staged and applied at an instant chosen elsewhere in the chip. On every falling edge of the comparator the block does three things: it pulses an event output for one clock, it sets a sticky service flag, and it raises an interrupt request if interrupts are enabled.

The write port has no back-pressure. A write is taken in the clock in which `wr_en` is high and is never refused or stalled. Direct duty writes take effect at once, so the period in progress may show old, new or mixed duty.

Top module: `pcm_pwm_gen`

## Requirements
- R1: After synchronous reset, `pwm_out`, `event_out`, `irq` and `flag_out` are 0, and the timer, period, duty and shadow registers are 0.
- R2: With period register value P, the timer counts 0 through P+1 and then returns to 0, so one period lasts P+2 clocks.
- R3: With the mode bit at 0 and duty value D, the output is high for exactly min(D, P+2) clocks of every period, in one contiguous run (one rising edge per period when 0 < D < P+2).
- R4: With duty 0xFFFF and P+1 below 0xFFFF, the output stays high in both modes and no event pulses occur.
- R5: With the mode bit at 1, the output is high in a period for every timer value t with D > rev(t), where rev maps timer bit i to bit 15-i. For example, with a period of 16 and D = 0x8000 the output alternates, with 8 ON clocks and 8 rising edges per period.
- R6: The R5 rule also holds when the period is not a power of two. With period 100 and D = 41943 (64 percent as a 16-bit fraction), the ON clocks are spread over many separate pulses.
- R7: A shadow write does not change the output. A one-clock `xfer_strobe` copies the shadow into the duty register. If a strobe and a direct duty write fall in the same clock, the strobe wins.
- R8: `event_out` is high for exactly one clock each time `pwm_out` falls from 1 to 0, in the same clock that `pwm_out` first reads 0.
- R9: `flag_out` is set in the clock of each event and stays set until a control write with bit 2 = 1 clears it. A set in the same clock as a clear wins.
- R10: `irq` equals `flag_out` AND the interrupt-enable control bit.
- R11: Write addresses are: 0 period, 1 duty, 2 shadow, 3 control. In the control word, bit 0 is the mode bit, bit 1 is the interrupt enable and bit 2 is the flag clear (acts only when written as 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register select (0 period, 1 duty, 2 shadow, 3 control) |
| wr_data | input | 16 | Write data |
| xfer_strobe | input | 1 | Copies shadow into duty register |
| pwm_out | output | 1 | Modulated output |
| event_out | output | 1 | One-clock pulse on each output falling edge |
| irq | output | 1 | Interrupt request (flag AND enable) |
| flag_out | output | 1 | Sticky service request flag |

## Verification
A wrong timer limit or a faulty reversal network changes the count of ON clocks or rising edges in every later period, so it shows within one period of P+2 clocks. A duty or shadow register that loads at the wrong time shows as the old count lasting past a strobe, or as a changed count after a shadow-only write. A stuck or mistimed event/flag path shows as an `event_out` that does not line up with the falling edge of `pwm_out` one clock earlier, or as `flag_out`/`irq` levels that are wrong right after a control write.

// File: rtl/pcm_pwm_pkg.sv
package pcm_pwm_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_SHADOW = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  localparam int CTRL_MODE_BIT  = 0;
  localparam int CTRL_IRQEN_BIT = 1;
  localparam int CTRL_CLEAR_BIT = 2;
endpackage

// File: rtl/pcm_period_timer.sv
module pcm_period_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] period,
  output logic [W-1:0] timer
);
  localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

  logic [W:0] limit;
  logic       at_end;

  // The last timer value is period+1, which gives a cycle of period+2 clocks.
  always_comb begin
    limit  = {1'b0, period} + ONE;
    at_end = ({1'b0, timer} >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst)         timer <= '0;
    else if (at_end) timer <= '0;
    else             timer <= timer + 1'b1;
  end
endmodule

// File: rtl/pcm_duty_regs.sv
module pcm_duty_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         duty_we,
  input  logic         shadow_we,
  input  logic         xfer,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] duty
);
  logic [W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst)            shadow <= '0;
    else if (shadow_we) shadow <= wdata;
  end

  // A transfer outranks a direct write in the same clock.
  always_ff @(posedge clk) begin
    if (rst)          duty <= '0;
    else if (xfer)    duty <= shadow;
    else if (duty_we) duty <= wdata;
  end
endmodule

// File: rtl/pcm_duty_cmp.sv
module pcm_duty_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] timer,
  input  logic [W-1:0] duty,
  input  logic         reverse,
  output logic         on
);
  logic [W-1:0] flipped;
  logic [W-1:0] operand;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign flipped[i] = timer[W-1-i];
  end

  always_comb begin
    operand = reverse ? flipped : timer;
    on      = (duty > operand);
  end
endmodule

// File: rtl/pcm_event_unit.sv
module pcm_event_unit (
  input  logic clk,
  input  logic rst,
  input  logic cmp_on,
  input  logic clear,
  input  logic irq_en,
  output logic pwm_out,
  output logic event_out,
  output logic flag,
  output logic irq
);
  logic falling;

  assign falling = pwm_out & ~cmp_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out   <= 1'b0;
      event_out <= 1'b0;
    end else begin
      pwm_out   <= cmp_on;
      event_out <= falling;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (falling) flag <= 1'b1;
    else if (clear)   flag <= 1'b0;
  end

  assign irq = flag & irq_en;
endmodule

// File: rtl/pcm_pwm_gen.sv
module pcm_pwm_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         xfer_strobe,
  output logic         pwm_out,
  output logic         event_out,
  output logic         irq,
  output logic         flag_out
);
  import pcm_pwm_pkg::*;

  logic [W-1:0] period_q;
  logic [W-1:0] timer_q;
  logic [W-1:0] duty_q;
  logic         mode_q;
  logic         irq_en_q;
  logic         period_we;
  logic         duty_we;
  logic         shadow_we;
  logic         ctrl_we;
  logic         flag_clr;
  logic         cmp_on;
  logic [W-1:0] unused_ctrl_bits;

  always_comb begin
    period_we = wr_en && (wr_addr == SEL_PERIOD);
    duty_we   = wr_en && (wr_addr == SEL_DUTY);
    shadow_we = wr_en && (wr_addr == SEL_SHADOW);
    ctrl_we   = wr_en && (wr_addr == SEL_CTRL);
    flag_clr  = ctrl_we && wr_data[CTRL_CLEAR_BIT];
  end

  assign unused_ctrl_bits = wr_data;

  always_ff @(posedge clk) begin
    if (rst)            period_q <= '0;
    else if (period_we) period_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 1'b0;
      irq_en_q <= 1'b0;
    end else if (ctrl_we) begin
      mode_q   <= wr_data[CTRL_MODE_BIT];
      irq_en_q <= wr_data[CTRL_IRQEN_BIT];
    end
  end

  pcm_period_timer #(.W(W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .period (period_q),
    .timer  (timer_q)
  );

  pcm_duty_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .duty_we   (duty_we),
    .shadow_we (shadow_we),
    .xfer      (xfer_strobe),
    .wdata     (wr_data),
    .duty      (duty_q)
  );

  pcm_duty_cmp #(.W(W)) u_cmp (
    .timer   (timer_q),
    .duty    (duty_q),
    .reverse (mode_q),
    .on      (cmp_on)
  );

  pcm_event_unit u_evt (
    .clk       (clk),
    .rst       (rst),
    .cmp_on    (cmp_on),
    .clear     (flag_clr),
    .irq_en    (irq_en_q),
    .pwm_out   (pwm_out),
    .event_out (event_out),
    .flag      (flag_out),
    .irq       (irq)
  );
endmodule

// File: rtl/pcm_pwm_chk.sv
module pcm_pwm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         xfer_strobe,
  input logic         duty_we,
  input logic         flag_clr,
  input logic         pwm_out,
  input logic         event_out,
  input logic         irq,
  input logic         flag_out,
  input logic [W-1:0] timer_q,
  input logic [W-1:0] period_q,
  input logic [W-1:0] duty_q
);
  logic [W:0] lim;
  assign lim = {1'b0, period_q} + {{W{1'b0}}, 1'b1};

  assert_timer_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, timer_q} >= lim) |=> (timer_q == '0));

  assert_event_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(pwm_out) |-> event_out);

  assert_event_after_high_R8: assert property (@(posedge clk) disable iff (rst)
    event_out |-> (!pwm_out && $past(pwm_out)));

  assert_event_single_R8: assert property (@(posedge clk) disable iff (rst)
    event_out |=> !event_out);

  assert_flag_on_event_R9: assert property (@(posedge clk) disable iff (rst)
    event_out |-> flag_out);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_out && !flag_clr) |=> flag_out);

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag_out);

  assert_duty_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!xfer_strobe && !duty_we) |=> $stable(duty_q));
endmodule

bind pcm_pwm_gen pcm_pwm_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .xfer_strobe (xfer_strobe),
  .duty_we     (duty_we),
  .flag_clr    (flag_clr),
  .pwm_out     (pwm_out),
  .event_out   (event_out),
  .irq         (irq),
  .flag_out    (flag_out),
  .timer_q     (timer_q),
  .period_q    (period_q),
  .duty_q      (duty_q)
);

// File: tb/tb_pcm_pwm_gen.sv
module tb_pcm_pwm_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        xfer_strobe = 1'b0;
  logic        pwm_out, event_out, irq, flag_out;

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  typedef struct {
    string tag;
    int    len;
    int    on;
    int    rises;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  pcm_pwm_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .xfer_strobe(xfer_strobe), .pwm_out(pwm_out), .event_out(event_out),
    .irq(irq), .flag_out(flag_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rev16(input int t);
    int r = 0;
    for (int b = 0; b < 16; b++) if (((t >> b) & 1) != 0) r |= (1 << (15 - b));
    return r;
  endfunction

  // Expected per-period ON count and rising-edge count from R3/R5.
  task automatic push_expect(input string tag, input int duty, input int per, input int mode);
    exp_t e;
    int n = per + 2;
    int on_cnt = 0;
    int rise_cnt = 0;
    bit prev;
    bit cur;
    prev = (duty > (mode != 0 ? rev16(n - 1) : n - 1));
    for (int t = 0; t < n; t++) begin
      cur = (duty > (mode != 0 ? rev16(t) : t));
      if (cur) on_cnt++;
      if (cur && !prev) rise_cnt++;
      prev = cur;
    end
    e.tag = tag; e.len = n; e.on = on_cnt; e.rises = rise_cnt;
    sb_q.push_back(e);
  endtask

  // Monitor: samples one full period plus one clock per scoreboard item.
  initial begin
    forever begin
      exp_t e;
      int on_cnt, rise_cnt, ev_cnt, misalign;
      bit prev_p;
      wait (sb_q.size() > 0);
      e = sb_q.pop_front();
      on_cnt = 0; rise_cnt = 0; ev_cnt = 0; misalign = 0;
      @(negedge clk);
      prev_p = pwm_out;
      if (pwm_out) on_cnt++;
      if (event_out) ev_cnt++;
      for (int i = 1; i <= e.len; i++) begin
        @(negedge clk);
        if (pwm_out && !prev_p) rise_cnt++;
        if (event_out != (prev_p && !pwm_out)) misalign++;
        if (i < e.len) begin
          if (pwm_out) on_cnt++;
          if (event_out) ev_cnt++;
        end
        prev_p = pwm_out;
      end
      check({e.tag, " on clocks"}, on_cnt, e.on);
      check({e.tag, " rising edges"}, rise_cnt, e.rises);
      check({e.tag, " event pulses R8"}, ev_cnt, e.rises);
      check({e.tag, " event alignment R8"}, misalign, 0);
      done_cnt++;
    end
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input string tag, input int duty, input int per, input int mode);
    int target = done_cnt + 1;
    repeat (per + 8) @(negedge clk);
    push_expect(tag, duty, per, mode);
    wait (done_cnt == target);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pwm_out after reset", pwm_out, 0);
    check("R1 event_out after reset", event_out, 0);
    check("R1 irq after reset", irq, 0);
    check("R1 flag_out after reset", flag_out, 0);

    // R11 map: period=0, duty=1, shadow=2, ctrl=3 (bit0 mode, bit1 irq_en, bit2 clear)
    wr(3, 0);
    wr(0, 8); wr(1, 3);
    measure("R3 R2 R11 mode0 P=8 D=3", 3, 8, 0);
    wr(1, 0);
    measure("R3 mode0 D=0", 0, 8, 0);
    wr(0, 98); wr(1, 64);
    measure("R3 R2 mode0 period100 D=64", 64, 98, 0);
    wr(0, 8); wr(1, 16'hFFFF);
    measure("R4 mode0 full duty", 16'hFFFF, 8, 0);
    wr(3, 1);
    measure("R4 mode1 full duty", 16'hFFFF, 8, 1);
    wr(0, 14); wr(1, 16'h8000);
    measure("R5 mode1 period16 half", 16'h8000, 14, 1);
    wr(0, 98); wr(1, 41943);
    measure("R6 mode1 period100 64pct", 41943, 98, 1);

    // R7: shadow staging and transfer
    wr(3, 0); wr(0, 8); wr(1, 3);
    wr(2, 6);
    measure("R7 shadow write ignored", 3, 8, 0);
    @(negedge clk); xfer_strobe = 1'b1;
    @(negedge clk); xfer_strobe = 1'b0;
    measure("R7 after transfer", 6, 8, 0);
    wr(2, 2);
    @(negedge clk);
    xfer_strobe = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd5;
    @(negedge clk);
    xfer_strobe = 1'b0; wr_en = 1'b0;
    measure("R7 transfer beats direct write", 2, 8, 0);

    // R9/R10: flag and interrupt
    check("R9 flag set by events", flag_out, 1);
    check("R10 irq masked when disabled", irq, 0);
    wr(3, 2);
    check("R10 irq follows flag when enabled", irq, 1);
    wr(1, 0);
    repeat (6) @(negedge clk);
    wr(3, 6);
    check("R9 flag cleared by clear bit", flag_out, 0);
    check("R10 irq low after clear", irq, 0);
    repeat (20) @(negedge clk);
    check("R9 flag stays clear without events", flag_out, 0);
    wr(1, 3);
    repeat (20) @(negedge clk);
    check("R9 flag set again by new event", flag_out, 1);
    check("R10 irq raised by new event", irq, 1);

    finish_run();
  end
endmodule